// File: doc/BRIEF.md
# Buffered SPI Master with Per-Select Timing

This block is an SPI master driven through a small register port. Software sets up a mode register and one timing register per peripheral, then writes a byte to the transmit register. That write launches an 8-bit frame. The frame goes out MSB first in SPI mode 0: the clock idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge. The block drives one of four active-low selects. The byte received on MISO is placed in a receive register.

Each select has two timing values. One is a lead-in delay between asserting the select and the first clock edge. The other is a gap inserted between back-to-back frames to the same select. The transmit register is a one-deep holding stage, so software can queue the next byte while a frame is still shifting, and the select stays asserted across the queued frames.

The select can be fixed by the mode register or carried with each transmit write. A receive overrun is flagged when a new frame lands before the last one was read. While that flag is set, the receive register is frozen, and the flag clears only when software reads the status register.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, all four selects are high, the serial clock is low, and the status register (address 3) reads 0x0001: bit0 tx_empty=1, bit1 rx_full=0, bit2 overrun=0.
- R2: With enable set (mode register address 0, bit0), a write to address 1 sends bits[7:0] MSB first in mode 0. MOSI holds steady while the clock is high. The byte shifted in from MISO then reads back at address 2 and sets rx_full. Reading address 2 clears rx_full.
- R3: The serial clock's high and low phases each last H system clocks. H is the divider field (mode bits[11:4]), and a divider of 0 is treated as 1.
- R4: The first rising clock edge comes pre+H system clocks after the select asserts. Here pre is bits[7:0] of that select's timing register (address 4+select).
- R5: When a byte is waiting at the end of a frame for the same select, the select stays asserted. The next frame's first rising edge then follows the last falling edge after gap+H system clocks, where gap is bits[15:8] of the timing register.
- R6: When no byte is waiting at the end of a frame, all selects return high.
- R7: With mode bit1 = 0 (fixed selection), the frame uses the select in mode bits[3:2], and bits[9:8] of the transmit write are ignored.
- R8: With mode bit1 = 1 (variable selection), each frame uses the select in bits[9:8] of its transmit write. At most one select is low at a time, and a change of select releases all selects before the new one asserts.
- R9: A frame that completes while rx_full is set raises overrun and leaves the receive register unchanged. While overrun is set, no frame is loaded, even after address 2 has been read. A read of address 3 clears overrun.
- R10: tx_empty goes to 0 on a transmit write and returns to 1 once the engine takes the byte.
- R11: While enable is 0, a pending byte is held and no select asserts. Setting enable later starts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags on the read registers) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from the address |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 4 | Active-low peripheral selects |

## Verification
The bench measures phase lengths of the serial clock in system cycles. A divider, lead-in or gap counter that is off by one shows up as a wrong phase length, and so does a divider of 0 that is not clamped to 1. It queues a second byte during a frame and checks that the select is asserted only once and that the gap appears. In variable mode it checks that the select is re-asserted when the select changes. A design that takes the select from the wrong source lights the wrong select, which the bench catches. The overrun test reads the receive register between frames, and it catches a design that reloads the receive register while the flag is set or clears the flag on the wrong read.

// File: rtl/spibm_pkg.sv
package spibm_pkg;

    localparam int DATA_W = 8;
    localparam int SEL_N  = 4;
    localparam int SEL_W  = $clog2(SEL_N);
    localparam int DLY_W  = 8;
    localparam int DIV_W  = 8;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;
    localparam int BIT_W  = $clog2(DATA_W);

    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_TX   = 3'd1;
    localparam logic [ADDR_W-1:0] A_RX   = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd3;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] fixed_sel;
        logic             var_sel;
        logic             en;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef struct packed {
        logic [DLY_W-1:0] gap;
        logic [DLY_W-1:0] pre;
    } timing_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_GAP
    } eng_st_t;

    function automatic logic [DIV_W-1:0] half_of(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction

    function automatic logic [SEL_W-1:0] pick_sel(input mode_t m, input logic [SEL_W-1:0] s);
        return m.var_sel ? s : m.fixed_sel;
    endfunction

endpackage

// File: rtl/spibm_regs.sv
module spibm_regs
    import spibm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output mode_t             mode,
    output timing_t           timing [SEL_N],
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic [SEL_W-1:0]  tx_sel,
    input  logic              pop,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_byte
);

    logic [DATA_W-1:0] rx_data;
    logic              rx_full;
    logic              ovr;
    logic              rx_rd, st_rd, load, hit_ovr;

    assign rx_rd   = rd && (addr == A_RX);
    assign st_rd   = rd && (addr == A_STAT);
    assign hit_ovr = done && !ovr && rx_full && !rx_rd;
    assign load    = done && !ovr && !hit_ovr;

    for (genvar i = 0; i < SEL_N; i++) begin : g_tim
        timing_t tim_q;
        always_ff @(posedge clk) begin
            if (rst)
                tim_q <= '0;
            else if (wr && addr[ADDR_W-1] && addr[SEL_W-1:0] == SEL_W'(i))
                tim_q <= timing_t'(wdata);
        end
        assign timing[i] = tim_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
            tx_sel   <= '0;
            rx_data  <= '0;
            rx_full  <= 1'b0;
            ovr      <= 1'b0;
        end else begin
            if (wr && addr == A_MODE)
                mode <= mode_t'(wdata[MODE_W-1:0]);

            if (wr && addr == A_TX) begin
                tx_valid <= 1'b1;
                tx_data  <= wdata[DATA_W-1:0];
                tx_sel   <= wdata[DATA_W +: SEL_W];
            end else if (pop) begin
                tx_valid <= 1'b0;
            end

            if (load) begin
                rx_data <= rx_byte;
                rx_full <= 1'b1;
            end else if (rx_rd) begin
                rx_full <= 1'b0;
            end

            if (hit_ovr)
                ovr <= 1'b1;
            else if (st_rd)
                ovr <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr[ADDR_W-1]) begin
            rdata = REG_W'(timing[addr[SEL_W-1:0]]);
        end else begin
            case (addr)
                A_MODE:  rdata = REG_W'(mode);
                A_RX:    rdata = REG_W'(rx_data);
                A_STAT:  rdata = REG_W'({ovr, rx_full, !tx_valid});
                default: rdata = '0;
            endcase
        end
    end

    a_r10_pop_needs_data: assert property (@(posedge clk) disable iff (rst)
        pop |-> tx_valid);
    a_r9_rx_frozen: assert property (@(posedge clk) disable iff (rst)
        $past(ovr) |-> $stable(rx_data));
    a_r9_ovr_needs_full: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(rx_full));

endmodule

// File: rtl/spibm_engine.sv
module spibm_engine
    import spibm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mode_t             mode,
    input  timing_t           timing [SEL_N],
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [SEL_W-1:0]  tx_sel,
    input  logic              miso,
    output logic              pop,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sclk,
    output logic              mosi,
    output logic [SEL_N-1:0]  cs_n
);

    eng_st_t           st;
    logic [DLY_W-1:0]  cnt;
    logic [DIV_W-1:0]  hc;
    logic [BIT_W-1:0]  bitn;
    logic [DATA_W-1:0] tsh, rsh;
    logic [SEL_W-1:0]  cur_sel;
    logic [DIV_W-1:0]  half;
    logic [SEL_W-1:0]  nsel;
    logic              phase_end, chain;

    assign half      = half_of(mode.div);
    assign nsel      = pick_sel(mode, tx_sel);
    assign phase_end = (st == ST_SHIFT) && (hc == half - DIV_W'(1));
    assign done      = phase_end && sclk && (bitn == BIT_W'(DATA_W - 1));
    assign chain     = mode.en && tx_valid && (nsel == cur_sel);
    assign pop       = ((st == ST_IDLE) && mode.en && tx_valid) || (done && chain);
    assign rx_byte   = rsh;
    assign mosi      = tsh[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            hc      <= '0;
            bitn    <= '0;
            tsh     <= '0;
            rsh     <= '0;
            cur_sel <= '0;
            sclk    <= 1'b0;
            cs_n    <= '1;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (mode.en && tx_valid) begin
                        tsh     <= tx_data;
                        cur_sel <= nsel;
                        cs_n    <= ~(SEL_N'(1) << nsel);
                        hc      <= '0;
                        bitn    <= '0;
                        if (timing[nsel].pre == '0) begin
                            st <= ST_SHIFT;
                        end else begin
                            st  <= ST_LEAD;
                            cnt <= timing[nsel].pre;
                        end
                    end
                end
                ST_LEAD, ST_GAP: begin
                    if (cnt == DLY_W'(1)) begin
                        st <= ST_SHIFT;
                        hc <= '0;
                    end else begin
                        cnt <= cnt - DLY_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (phase_end) begin
                        hc <= '0;
                        if (!sclk) begin
                            sclk <= 1'b1;
                            rsh  <= {rsh[DATA_W-2:0], miso};
                        end else begin
                            sclk <= 1'b0;
                            if (done) begin
                                bitn <= '0;
                                if (chain) begin
                                    tsh <= tx_data;
                                    if (timing[cur_sel].gap != '0) begin
                                        st  <= ST_GAP;
                                        cnt <= timing[cur_sel].gap;
                                    end
                                end else begin
                                    st   <= ST_IDLE;
                                    cs_n <= '1;
                                end
                            end else begin
                                bitn <= bitn + BIT_W'(1);
                                tsh  <= {tsh[DATA_W-2:0], 1'b0};
                            end
                        end
                    end else begin
                        hc <= hc + DIV_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    a_r6_idle_released: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> (&cs_n));
    a_r8_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));
    a_r4_lead_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LEAD) |-> (!sclk && !(&cs_n)));
    a_r2_clock_in_shift: assert property (@(posedge clk) disable iff (rst)
        sclk |-> (st == ST_SHIFT));
    a_r2_mosi_steady: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spibm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [SEL_N-1:0]  cs_n
);

    mode_t             mode;
    timing_t           timing [SEL_N];
    logic              tx_valid, pop, done;
    logic [DATA_W-1:0] tx_data, rx_byte;
    logic [SEL_W-1:0]  tx_sel;

    spibm_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .mode     (mode),
        .timing   (timing),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_sel   (tx_sel),
        .pop      (pop),
        .done     (done),
        .rx_byte  (rx_byte)
    );

    spibm_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .timing   (timing),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_sel   (tx_sel),
        .miso     (miso),
        .pop      (pop),
        .done     (done),
        .rx_byte  (rx_byte),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n)
    );

endmodule

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        miso = 1'b0;
    logic        sclk, mosi;
    logic [3:0]  cs_n;

    always #4 clk = ~clk;

    spi_burst_master u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // peripheral model, mode 0
    logic [7:0] s_src [8];
    logic [7:0] s_got [8];
    logic [3:0] s_cs  [8];
    logic [7:0] s_out = '0;
    logic [7:0] s_cap = '0;
    int s_idx = 0, s_bits = 0, cs_starts = 0;
    wire cs_any = &cs_n;

    always @(negedge cs_any) begin
        cs_starts++;
        s_out  = s_src[s_idx & 7];
        miso   = s_out[7];
        s_bits = 0;
    end

    always @(posedge sclk) begin
        s_cap = {s_cap[6:0], mosi};
        s_bits++;
        if (s_bits == 8) begin
            s_got[s_idx & 7] = s_cap;
            s_cs[s_idx & 7]  = cs_n;
            s_idx++;
            s_bits = 0;
            s_out  = s_src[s_idx & 7];
        end
    end

    always @(negedge sclk) begin
        if (s_bits != 0) s_out = {s_out[6:0], 1'b0};
        miso = s_out[7];
    end

    // phase-length monitor, sampled at the falling system clock edge
    int lo = 0, hi = 0, nlo = 0, nhi = 0;
    int lo_log [32];
    int hi_log [32];

    always @(negedge clk) begin
        if (cs_any === 1'b1) begin
            lo = 0; hi = 0;
        end else if (sclk === 1'b0) begin
            if (hi > 0 && nhi < 32) begin hi_log[nhi] = hi; nhi++; end
            hi = 0; lo++;
        end else if (sclk === 1'b1) begin
            if (lo > 0 && nlo < 32) begin lo_log[nlo] = lo; nlo++; end
            lo = 0; hi++;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic clear_logs();
        @(negedge clk);
        #1;
        nlo = 0; nhi = 0; lo = 0; hi = 0; s_idx = 0; cs_starts = 0;
    endtask

    task automatic wait_quiet();
        int q;
        repeat (4) @(negedge clk);
        q = 0;
        while (q < 4) begin
            @(negedge clk);
            q = cs_any ? q + 1 : 0;
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 cs_n", int'(cs_n), 'hF);
        check("R1 sclk", int'(sclk), 0);
        rd(3'd3, v);
        check("R1 status", int'(v), 1);
    endtask

    task automatic t_basic();
        logic [15:0] v;
        clear_logs();
        s_src[0] = 8'h3C;
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'h0021);
        wr(3'd1, 16'h00A5);
        wait_quiet();
        check("R2 mosi byte", int'(s_got[0]), 'hA5);
        check("R7 fixed select 0", int'(s_cs[0]), 'hE);
        check("R3 high phase div2", hi_log[0], 2);
        check("R4 lead with pre 0", lo_log[0], 2);
        check("R6 released", int'(cs_n), 'hF);
        check("R6 one assertion", cs_starts, 1);
        rd(3'd3, v);
        check("R2 status full", int'(v), 3);
        rd(3'd2, v);
        check("R2 rx byte", int'(v), 'h3C);
        rd(3'd3, v);
        check("R2 full cleared", int'(v), 1);
    endtask

    task automatic t_div0();
        logic [15:0] v;
        clear_logs();
        s_src[0] = 8'h00;
        wr(3'd0, 16'h0001);
        wr(3'd1, 16'h0081);
        wait_quiet();
        check("R3 div0 high", hi_log[0], 1);
        check("R3 div0 high later", hi_log[3], 1);
        check("R3 div0 low", lo_log[2], 1);
        rd(3'd2, v);
    endtask

    task automatic t_pre();
        logic [15:0] v;
        clear_logs();
        s_src[0] = 8'h55;
        wr(3'd5, 16'h0005);
        wr(3'd0, 16'h0025);
        wr(3'd1, 16'h00C3);
        wait_quiet();
        check("R4 lead pre5 div2", lo_log[0], 7);
        check("R7 fixed select 1", int'(s_cs[0]), 'hD);
        check("R2 byte after lead", int'(s_got[0]), 'hC3);
        rd(3'd2, v);
    endtask

    task automatic t_gap();
        logic [15:0] v;
        clear_logs();
        s_src[0] = 8'h81; s_src[1] = 8'h42;
        wr(3'd5, 16'h0400);
        wr(3'd0, 16'h0025);
        wr(3'd1, 16'h0011);
        wr(3'd1, 16'h0022);
        wait_quiet();
        check("R5 single assertion", cs_starts, 1);
        check("R5 first lead", lo_log[0], 2);
        check("R5 inner low", lo_log[7], 2);
        check("R5 gap4 div2", lo_log[8], 6);
        check("R5 byte 0", int'(s_got[0]), 'h11);
        check("R5 byte 1", int'(s_got[1]), 'h22);
        rd(3'd2, v);
        check("R9 first byte kept", int'(v), 'h81);
        rd(3'd3, v);
        check("R9 overrun flagged", int'(v), 5);
        rd(3'd3, v);
        check("R9 overrun cleared", int'(v), 1);
        wr(3'd5, 16'h0000);
    endtask

    task automatic t_fixed_ignore();
        logic [15:0] v;
        clear_logs();
        s_src[0] = 8'h00;
        wr(3'd0, 16'h0019);
        wr(3'd1, 16'h035A);
        wait_quiet();
        check("R7 upper bits ignored", int'(s_cs[0]), 'hB);
        check("R7 byte", int'(s_got[0]), 'h5A);
        rd(3'd2, v);
    endtask

    task automatic t_var();
        logic [15:0] v;
        clear_logs();
        s_src[0] = 8'h00; s_src[1] = 8'h00;
        wr(3'd0, 16'h0013);
        wr(3'd1, 16'h0166);
        wr(3'd1, 16'h0399);
        wait_quiet();
        check("R8 first select", int'(s_cs[0]), 'hD);
        check("R8 second select", int'(s_cs[1]), 'h7);
        check("R8 reasserted", cs_starts, 2);
        check("R8 second byte", int'(s_got[1]), 'h99);
        rd(3'd2, v);
        rd(3'd3, v);
    endtask

    task automatic t_ovr();
        logic [15:0] v;
        clear_logs();
        s_src[0] = 8'hC1; s_src[1] = 8'hC2; s_src[2] = 8'hC3; s_src[3] = 8'hC4;
        wr(3'd0, 16'h0011);
        wr(3'd1, 16'h0001);
        wait_quiet();
        wr(3'd1, 16'h0002);
        wait_quiet();
        rd(3'd2, v);
        check("R9 old byte kept", int'(v), 'hC1);
        wr(3'd1, 16'h0003);
        wait_quiet();
        rd(3'd3, v);
        check("R9 frozen while set", int'(v), 5);
        rd(3'd2, v);
        check("R9 no load while set", int'(v), 'hC1);
        rd(3'd3, v);
        check("R9 cleared by status read", int'(v), 1);
        wr(3'd1, 16'h0004);
        wait_quiet();
        rd(3'd2, v);
        check("R9 loads after clear", int'(v), 'hC4);
    endtask

    task automatic t_enable();
        logic [15:0] v;
        clear_logs();
        s_src[0] = 8'h00;
        wr(3'd0, 16'h0010);
        wr(3'd1, 16'h0077);
        repeat (40) @(negedge clk);
        check("R11 no select while disabled", cs_starts, 0);
        rd(3'd3, v);
        check("R10 tx not empty", int'(v), 0);
        wr(3'd0, 16'h0011);
        wait_quiet();
        check("R11 held byte sent", int'(s_got[0]), 'h77);
        rd(3'd3, v);
        check("R10 tx empty again", int'(v & 16'h1), 1);
        rd(3'd2, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_div0();
        t_pre();
        t_gap();
        t_fixed_ignore();
        t_var();
        t_ovr();
        t_enable();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule